// File: doc/BRIEF.md
# Dual-Channel Pin-Event Timestamp Capture

This block records when an external pin event happened by storing a slice of a free-running low-speed time base. Each of two channels watches its own input pin. A selected edge on that pin raises the channel's interrupt request. If the channel is enabled and its capture flag is clear, the channel then waits for the next falling edge of the low-speed clock. On that edge it stores eight taps of the time base and sets its capture flag.

The whole block runs on the system clock. The low-speed clock arrives as a one-cycle strobe marking each of its falling edges. Pins pass through a two-flop synchronizer before edge detection. While a channel's flag is set, that channel captures nothing more. Software reads the stored value and then writes any value to the channel's capture register. That write clears the flag and re-arms the channel. Reads have no side effects.

Top module: `tscap_unit`

## Requirements
- R1: After reset, every register reads zero and both `irq` bits are 0.
- R2: The time base is a 10-bit binary counter that starts at 0 and steps once per `ls_fall` strobe. A capture stores counter bits [9:2] of the value the counter holds after that strobe, in capture register bits [7:0].
- R3: Control register (address 0) bit 2+2c..3+2c selects the edge for channel c: 0 none, 1 rising, 2 falling, 3 both. A selected edge sets that channel's request flag, which appears on `irq[c]` and on status bit 2+c. Bits 0 and 1 of the control register are the channel enables.
- R4: A capture happens only in a cycle with `ls_fall` high, after a pending event. The capture register and the capture flag (status bit c, address 1) update together in that cycle, never before it.
- R5: A selected edge on a disabled channel sets its request flag but causes no capture.
- R6: While a channel's capture flag is 1, further pin events and strobes leave its capture register and flag unchanged.
- R7: A write to a channel's capture register (address 2+c) clears that channel's capture flag. The written data is discarded, and the register keeps its value.
- R8: Writing status with a 1 in bit 2+c clears request flag c. Reading any register changes nothing.
- R9: If a capture-register write and a capture of the same channel fall in the same cycle, the capture wins. The flag stays 1 and the register takes the new value.
- R10: Clearing a channel's enable cancels its pending capture. The flag and the register are left as they were, and re-enabling without a new event captures nothing.
- R11: Events, captures and clears on one channel leave the other channel's flag and register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ls_fall | input | 1 | One-cycle strobe at each low-speed clock falling edge |
| pin | input | 2 | Asynchronous event pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2/3 capture registers |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| irq | output | 2 | Per-channel pin request flags |

## Verification
A software clear of a capture flag can fall in the same cycle as a low-speed strobe that completes a pending capture on that channel. The bench arms channel 0 and raises an event. It then drives the strobe and a write to address 2 in one cycle. It judges the result by reading back a set flag and a capture register that holds the freshly computed time-base slice. A second overlap is a request-flag clear on one channel during activity on the other. It is judged by reading both channels' state afterwards.

// File: rtl/tscap_pkg.sv
// Package: shared types for the timestamp capture unit.
// Assumes: edge-select codes are two bits wide.
package tscap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;
endpackage

// File: rtl/tscap_timebase.sv
// Free-running time-base counter stepped by the low-speed falling strobe.
// Outputs the tap slice of the value the counter will hold after a strobe.
// Assumes: TAP_LO + CAP_W <= TB_W.
module tscap_timebase #(
    parameter int TB_W   = 10,
    parameter int TAP_LO = 2,
    parameter int CAP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CAP_W-1:0] taps_next
);
    logic [TB_W-1:0] cnt_q;
    logic [TB_W-1:0] cnt_inc;

    // next counter value
    assign cnt_inc   = cnt_q + TB_W'(1);
    assign taps_next = cnt_inc[TAP_LO +: CAP_W];

    // counter register, advances on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/tscap_sync_edge.sv
// Two-flop synchronizer plus selectable edge detector for one pin.
// Assumes: the pin is asynchronous to clk. evt is a one-cycle pulse.
module tscap_sync_edge
    import tscap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_async,
    input  edge_sel_e  sel,
    output logic       evt
);
    logic s1_q, s2_q, prev_q;

    // synchronizer chain and previous-value stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin_async;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // edge qualification by select code
    always_comb begin
        unique case (sel)
            EDGE_RISE: evt = s2_q & ~prev_q;
            EDGE_FALL: evt = ~s2_q & prev_q;
            EDGE_BOTH: evt = s2_q ^ prev_q;
            default:   evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/tscap_channel.sv
// One capture channel: request flag, pending capture, capture flag and register.
// Assumes: evt, strobe, clr and irq_clr are single-cycle pulses in the clk domain.
module tscap_channel #(
    parameter int CAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             evt,
    input  logic             strobe,
    input  logic             clr,
    input  logic             irq_clr,
    input  logic [CAP_W-1:0] taps,
    output logic             irq_flag,
    output logic             capf,
    output logic [CAP_W-1:0] capr
);
    logic pend_q;
    logic take;

    // capture fires at a strobe when armed and pending
    assign take = en & pend_q & ~capf & strobe;

    // request flag: set by event, cleared by status write
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (evt)     irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end

    // pending capture: armed by event, consumed by capture or disable
    always_ff @(posedge clk) begin
        if (!rst_n)               pend_q <= 1'b0;
        else if (!en || take)     pend_q <= 1'b0;
        else if (evt && !capf)    pend_q <= 1'b1;
    end

    // capture flag: capture beats a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n)    capf <= 1'b0;
        else if (take) capf <= 1'b1;
        else if (clr)  capf <= 1'b0;
    end

    // capture register, loaded only on capture
    always_ff @(posedge clk) begin
        if (!rst_n)    capr <= '0;
        else if (take) capr <= taps;
    end
endmodule

// File: rtl/tscap_unit.sv
// Top of the timestamp capture unit: time base, per-channel edge detect and
// capture, and a flat register port. Map: 0 control (enables, edge selects),
// 1 status (capture flags, W1C request flags), 2+c capture register of channel c.
// Assumes: 3*NCH <= DATA_W and CAP_W <= DATA_W.
module tscap_unit
    import tscap_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int TB_W   = 10,
    parameter int TAP_LO = 2,
    parameter int CAP_W  = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(NCH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ls_fall,
    input  logic [NCH-1:0]    pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam int                SEL_W  = 2 * NCH;

    logic [NCH-1:0]         en_q;
    logic [SEL_W-1:0]       sel_q;
    logic [NCH-1:0]         capf;
    logic [NCH-1:0]         irq_flag;
    logic [NCH*CAP_W-1:0]   capr_flat;
    logic [CAP_W-1:0]       taps;

    // control register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            en_q  <= wdata[NCH-1:0];
            sel_q <= wdata[NCH +: SEL_W];
        end
    end

    tscap_timebase #(.TB_W(TB_W), .TAP_LO(TAP_LO), .CAP_W(CAP_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (ls_fall),
        .taps_next (taps)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic evt;
        tscap_sync_edge u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin[c]),
            .sel       (edge_sel_e'(sel_q[2*c +: 2])),
            .evt       (evt)
        );
        tscap_channel #(.CAP_W(CAP_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_q[c]),
            .evt      (evt),
            .strobe   (ls_fall),
            .clr      (wr_en && addr == ADDR_W'(c + 2)),
            .irq_clr  (wr_en && addr == A_STAT && wdata[NCH + c]),
            .taps     (taps),
            .irq_flag (irq_flag[c]),
            .capf     (capf[c]),
            .capr     (capr_flat[c*CAP_W +: CAP_W])
        );
    end

    assign irq = irq_flag;

    // side-effect-free read mux
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[NCH-1:0]     = en_q;
            rdata[NCH +: SEL_W] = sel_q;
        end else if (addr == A_STAT) begin
            rdata[NCH-1:0]   = capf;
            rdata[NCH +: NCH] = irq_flag;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(c + 2)) rdata[CAP_W-1:0] = capr_flat[c*CAP_W +: CAP_W];
            end
        end
    end
endmodule

// File: rtl/tscap_unit_chk.sv
// Checker for tscap_unit, attached by bind. Observes flags, registers and the
// register port per channel.
module tscap_unit_chk #(
    parameter int NCH    = 2,
    parameter int CAP_W  = 8,
    parameter int ADDR_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ls_fall,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [NCH-1:0]       en_q,
    input logic [2*NCH-1:0]     sel_q,
    input logic [NCH-1:0]       capf,
    input logic [NCH*CAP_W-1:0] capr_flat,
    input logic [NCH-1:0]       irq
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R4
        capf_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(capf[c]) |-> $past(ls_fall));
        // R6
        capr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            capf[c] |=> $stable(capr_flat[c*CAP_W +: CAP_W]));
        // R7
        capf_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(capf[c]) |-> $past(wr_en && addr == ADDR_W'(c + 2)));
        // R10
        disabled_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[c] |=> !$rose(capf[c]));
        // R3
        irq_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(sel_q[2*c +: 2] != 2'd0));
    end
endmodule

bind tscap_unit tscap_unit_chk #(.NCH(NCH), .CAP_W(CAP_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ls_fall   (ls_fall),
    .wr_en     (wr_en),
    .addr      (addr),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .capf      (capf),
    .capr_flat (capr_flat),
    .irq       (irq)
);

// File: tb/tscap_unit_tb.sv
module tscap_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ls_fall = 1'b0;
    logic [1:0] pin = 2'b00;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] irq;

    int n_run = 0;
    int n_fail = 0;
    int cnt_m = 0;
    logic [7:0] v, cap0, cap1;

    tscap_unit u_dut (.*);

    always #4 clk = ~clk;

    // vector: [4:3] edge sel, [2] pin start, [1] pin end, [0] expect event
    localparam logic [4:0] VEC [8] = '{
        5'b01_0_1_1, 5'b01_1_0_0, 5'b10_1_0_1, 5'b10_0_1_0,
        5'b11_0_1_1, 5'b11_1_0_1, 5'b00_0_1_0, 5'b00_1_0_0
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ls_fall = 1'b1;
            @(negedge clk); ls_fall = 1'b0;
            cnt_m = (cnt_m + 1) % 1024;
        end
    endtask

    task automatic set_pin(input int c, input logic val);
        @(negedge clk); pin[c] = val;
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [7:0] slice();
        return 8'((cnt_m >> 2) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 reg", v, 8'h00);
        end
        chk("R1 irq", {6'd0, irq}, 8'h00);

        // R3 R5 edge table on channel 0, channel disabled
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, {3'b000, VEC[i][4:3], 2'b00});
            set_pin(0, VEC[i][2]);
            wr(2'd1, 8'h0C);
            set_pin(0, VEC[i][1]);
            rd(2'd1, v);
            chk("R3 R5 table status", v, {5'd0, VEC[i][0], 2'b00});
            chk("R3 table irq", {6'd0, irq}, {7'd0, VEC[i][0]});
        end
        set_pin(0, 1'b0);
        wr(2'd1, 8'h0C);
        // R8 read has no side effect
        rd(2'd1, v); rd(2'd1, v); chk("R8 clear and read", v, 8'h00);

        strobe(300);
        // R4 deferred capture, rising on ch0 enabled
        wr(2'd0, 8'b0000_0101);
        set_pin(0, 1'b1);
        rd(2'd1, v); chk("R4 flag before strobe", v, 8'h04);
        rd(2'd2, v); chk("R4 capr before strobe", v, 8'h00);
        strobe(1);
        cap0 = slice();
        rd(2'd1, v); chk("R4 flag after strobe", v, 8'h05);
        rd(2'd2, v); chk("R2 capture value", v, cap0);

        // R6 locked while flag set
        set_pin(0, 1'b0); set_pin(0, 1'b1);
        strobe(7);
        rd(2'd2, v); chk("R6 capr held", v, cap0);
        rd(2'd1, v); chk("R6 flag held", v[1:0], 2'b01);

        // R8 W1C request flag ch0 only
        wr(2'd1, 8'h04);
        rd(2'd1, v); chk("R8 irq cleared", v, 8'h01);

        // R11 channel 1 capture while ch0 locked
        wr(2'd0, 8'b0101_0111);
        strobe(45);
        set_pin(1, 1'b1);
        strobe(1);
        cap1 = slice();
        rd(2'd3, v); chk("R11 ch1 capr", v, cap1);
        rd(2'd2, v); chk("R11 ch0 capr untouched", v, cap0);
        rd(2'd1, v); chk("R11 flags", v, 8'h0B);

        // R7 dummy write clears flag, data discarded
        wr(2'd2, 8'hA5);
        rd(2'd1, v); chk("R7 ch0 flag cleared", v[1:0], 2'b10);
        rd(2'd2, v); chk("R7 capr unchanged", v, cap0);
        rd(2'd3, v); chk("R11 ch1 after ch0 clear", v, cap1);

        // R10 disable cancels pending
        set_pin(0, 1'b0); set_pin(0, 1'b1);
        wr(2'd0, 8'b0101_0110);
        strobe(3);
        wr(2'd0, 8'b0101_0111);
        strobe(3);
        rd(2'd1, v); chk("R10 no capture", v[1:0], 2'b10);
        rd(2'd2, v); chk("R10 capr unchanged", v, cap0);

        // R9 clear write and capture in the same cycle
        strobe(21);
        set_pin(0, 1'b0); set_pin(0, 1'b1);
        @(negedge clk); ls_fall = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 8'h3C;
        @(negedge clk); ls_fall = 1'b0; wr_en = 1'b0;
        cnt_m = (cnt_m + 1) % 1024;
        cap0 = slice();
        rd(2'd1, v); chk("R9 flag stays", v[1:0], 2'b11);
        rd(2'd2, v); chk("R9 capr new", v, cap0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule